// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the register-level bridge of an 8042-compatible keyboard controller. On one side it serves a host I/O bus with two byte ports: the data port (host address bit A2 = 0, the classic 60h) and the command/status port (A2 = 1, 64h). On the other side it offers a local processor a bank of eight byte registers through a simple strobe interface. Bytes moving in each direction are held in an input buffer and an output buffer. Two flags in the host status byte report them: IBF (input buffer full) and OBF (output buffer full).

A per-command enable mask chooses which of eight well-known host commands the block executes on its own. All other commands, and every host byte while firmware is busy, go to the local processor. A command that is handed over also holds the block in firmware mode until firmware releases it. Pending-interrupt flags are raised on the rising edge of IBF and on the falling edge of OBF, and the local interrupt line is their OR.

The command engine is a four-state machine:
- `ST_IDLE` waits for host writes.
- `ST_DECODE` spends one cycle deciding between hardware and firmware.
- `ST_ARG` waits for the data byte that follows a write-type command.
- `ST_FW` is firmware mode.

Its transitions are:
- IDLE→DECODE on a command write.
- DECODE→IDLE for single-byte hardware commands.
- DECODE→ARG for D1h, D2h and D3h.
- DECODE→FW when the mask bit is clear or the code is unknown.
- ARG→IDLE on the data byte.
- ARG→DECODE when a new command replaces the pending one.
- FW→IDLE when firmware writes the exit bit.

The host must leave at least one idle cycle between write strobes.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the host status byte reads 00h, `irq_o` and `kb_reset_o` are low, and the local registers read as follows: control (address 3) 03h, mask (address 5) FFh, command byte (address 2) 00h, interrupt flags (address 4) 00h, output port (address 7) 00h.
- R2: Every host write stores its byte in the input buffer, which the local side reads at address 0. Status bit3 becomes 1 after a write with A2 = 1 and 0 after a write with A2 = 0.
- R3: A local write to address 1 loads the output buffer and sets OBF (status bit0). A host read with A2 = 0 returns the output buffer, and a host read with A2 = 1 returns the status byte.
- R4: A host read with A2 = 0 clears OBF at that clock edge.
- R5: The status byte is {parity error, timeout, auxiliary data, uninhibited, A2, system flag, IBF, OBF} from bit7 down to bit0. Bits 7..4 are written by the local side through address 6 bits 7..4, and bit2 mirrors bit2 of the command byte.
- R6: A command whose mask bit is set is executed without setting IBF. Mask bit0 covers 20h, bit1 C0h, bit2 D0h and bit6 E0h. These load the output buffer and set OBF two clocks after the write, with the following values:
  - 20h: the command byte.
  - C0h: `in_port_i`.
  - D0h: the output port.
  - E0h: {000000, `test_in_i`}.
- R7: With its mask bit set, each of these commands takes the next data byte:
  - D1h (mask bit3) writes it to the output port `p2_o`.
  - D2h (bit4) puts it in the output buffer with status bit5 = 0.
  - D3h (bit5) puts it in the output buffer with status bit5 = 1.
- R8: Command FEh with mask bit7 set drives `kb_reset_o` high for exactly one clock, two clocks after the write.
- R9: A command with a clear mask bit, or with a code outside the eight, sets IBF and the firmware-mode flag (address 4 bit2). In firmware mode every host write sets IBF and is not executed. Firmware mode ends when the local side writes 1 to address 4 bit2.
- R10: Address 4 bit1 is set on a rising edge of IBF when control bit1 is 1, and address 4 bit0 is set on a falling edge of OBF when control bit0 is 1. `irq_o` is the OR of the two bits, and writing 1 to either bit clears it.
- R11: A local read strobe at address 0 clears IBF. A host data write while no command argument is awaited sets IBF.
- R12: Bit7 of the command byte always reads 0, and bits 6..0 hold what the local side wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_a2 | input | 1 | Host address bit A2: 0 data port, 1 command/status port |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data: status when A2 = 1, output buffer when A2 = 0 |
| l_addr | input | 3 | Local register address |
| l_rd | input | 1 | Local read strobe (address 0 clears IBF) |
| l_wr | input | 1 | Local write strobe |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data |
| in_port_i | input | 8 | Input port value returned by C0h |
| test_in_i | input | 2 | Test inputs returned by E0h |
| p2_o | output | 8 | Output port register written by D1h |
| kb_reset_o | output | 1 | One-cycle reset pulse from FEh |
| irq_o | output | 1 | Local interrupt request |

## Verification
A state machine stuck in the wrong state shows up within two clocks of the next host command. A lost firmware-mode state lets a masked-off command execute, so OBF or `kb_reset_o` changes where only IBF should. A stuck ARG state swallows the next data byte, so IBF stays low. Broken edge detectors show as an interrupt flag missing one clock after IBF rises or OBF falls. Because every one of the 256 command codes is swept with the full mask, and each hardware command is then masked off one at a time, a decode fault against any single code appears in the status byte or the output buffer on the very next read.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int unsigned DW      = 8;
    localparam int unsigned AW      = 3;
    localparam int unsigned N_HWCMD = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ARG,
        ST_FW
    } kbc_state_t;

    // host command codes; position in this list equals the mask bit
    localparam logic [DW-1:0] CMD_RD_CB   = 8'h20;
    localparam logic [DW-1:0] CMD_RD_IN   = 8'hC0;
    localparam logic [DW-1:0] CMD_RD_P2   = 8'hD0;
    localparam logic [DW-1:0] CMD_WR_P2   = 8'hD1;
    localparam logic [DW-1:0] CMD_WR_KB   = 8'hD2;
    localparam logic [DW-1:0] CMD_WR_AUX  = 8'hD3;
    localparam logic [DW-1:0] CMD_RD_TEST = 8'hE0;
    localparam logic [DW-1:0] CMD_KBRST   = 8'hFE;

    // local register addresses
    localparam logic [AW-1:0] LA_IBUF  = 3'd0;
    localparam logic [AW-1:0] LA_OBUF  = 3'd1;
    localparam logic [AW-1:0] LA_CMDB  = 3'd2;
    localparam logic [AW-1:0] LA_CTRL  = 3'd3;
    localparam logic [AW-1:0] LA_IFLAG = 3'd4;
    localparam logic [AW-1:0] LA_MASK  = 3'd5;
    localparam logic [AW-1:0] LA_STAT  = 3'd6;
    localparam logic [AW-1:0] LA_PORT  = 3'd7;

    // one-hot mask position of a command code, zero when not a hardware command
    function automatic logic [N_HWCMD-1:0] hw_onehot(input logic [DW-1:0] code);
        logic [N_HWCMD-1:0] sel;
        sel[0] = (code == CMD_RD_CB);
        sel[1] = (code == CMD_RD_IN);
        sel[2] = (code == CMD_RD_P2);
        sel[3] = (code == CMD_WR_P2);
        sel[4] = (code == CMD_WR_KB);
        sel[5] = (code == CMD_WR_AUX);
        sel[6] = (code == CMD_RD_TEST);
        sel[7] = (code == CMD_KBRST);
        return sel;
    endfunction

endpackage

// File: rtl/kbc_cmd_fsm.sv
module kbc_cmd_fsm
    import kbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cmd_wr,
    input  logic               host_dat_wr,
    input  logic [DW-1:0]      host_wdata,
    input  logic [N_HWCMD-1:0] hw_mask,
    input  logic [DW-1:0]      cmd_byte,
    input  logic [DW-1:0]      in_port,
    input  logic [DW-1:0]      port_val,
    input  logic [1:0]         test_in,
    input  logic               fw_exit,
    output logic               fw_mode,
    output logic               ibf_set,
    output logic               obuf_load,
    output logic [DW-1:0]      obuf_val,
    output logic               aux_load,
    output logic               aux_val,
    output logic               port_load,
    output logic [DW-1:0]      port_next,
    output logic               rst_pulse
);

    kbc_state_t         state_q, state_d;
    logic [DW-1:0]      cur_cmd_q;
    logic [N_HWCMD-1:0] hit_vec;
    logic               hw_hit;
    logic               takes_arg;

    assign hit_vec   = hw_onehot(cur_cmd_q) & hw_mask;
    assign hw_hit    = |hit_vec;
    assign takes_arg = hit_vec[3] | hit_vec[4] | hit_vec[5];
    assign fw_mode   = (state_q == ST_FW);

    // state register and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_cmd_q <= '0;
        end else begin
            state_q <= state_d;
            if (host_cmd_wr && (state_q == ST_IDLE || state_q == ST_ARG)) begin
                cur_cmd_q <= host_wdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_cmd_wr) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (!hw_hit)        state_d = ST_FW;
                else if (takes_arg) state_d = ST_ARG;
                else                state_d = ST_IDLE;
            end
            ST_ARG: begin
                if (host_cmd_wr)      state_d = ST_DECODE;
                else if (host_dat_wr) state_d = ST_IDLE;
            end
            ST_FW: begin
                if (fw_exit) state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        ibf_set   = 1'b0;
        obuf_load = 1'b0;
        obuf_val  = '0;
        aux_load  = 1'b0;
        aux_val   = 1'b0;
        port_load = 1'b0;
        port_next = host_wdata;
        rst_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ibf_set = host_dat_wr;
            end
            ST_DECODE: begin
                if (!hw_hit) begin
                    ibf_set = 1'b1;
                end else begin
                    unique case (cur_cmd_q)
                        CMD_RD_CB: begin
                            obuf_load = 1'b1;
                            obuf_val  = {1'b0, cmd_byte[DW-2:0]};
                        end
                        CMD_RD_IN: begin
                            obuf_load = 1'b1;
                            obuf_val  = in_port;
                        end
                        CMD_RD_P2: begin
                            obuf_load = 1'b1;
                            obuf_val  = port_val;
                        end
                        CMD_RD_TEST: begin
                            obuf_load = 1'b1;
                            obuf_val  = {{(DW-2){1'b0}}, test_in};
                        end
                        CMD_KBRST: begin
                            rst_pulse = 1'b1;
                        end
                        default: begin
                            obuf_load = 1'b0;
                        end
                    endcase
                end
            end
            ST_ARG: begin
                if (host_dat_wr && !host_cmd_wr) begin
                    unique case (cur_cmd_q)
                        CMD_WR_P2: port_load = 1'b1;
                        CMD_WR_KB: begin
                            obuf_load = 1'b1;
                            obuf_val  = host_wdata;
                            aux_load  = 1'b1;
                            aux_val   = 1'b0;
                        end
                        CMD_WR_AUX: begin
                            obuf_load = 1'b1;
                            obuf_val  = host_wdata;
                            aux_load  = 1'b1;
                            aux_val   = 1'b1;
                        end
                        default: begin
                            port_load = 1'b0;
                        end
                    endcase
                end
            end
            ST_FW: begin
                ibf_set = host_cmd_wr | host_dat_wr;
            end
        endcase
    end

endmodule

// File: rtl/kbc_irq_unit.sv
module kbc_irq_unit #(
    parameter int unsigned     NSRC     = 2,
    parameter logic [NSRC-1:0] FALL_SEL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lvl,
    input  logic [NSRC-1:0] ie,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend,
    output logic            irq
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic lvl_q;
        logic edge_w;

        if (FALL_SEL[g]) begin : g_fall
            assign edge_w = lvl_q & ~lvl[g];
        end else begin : g_rise
            assign edge_w = lvl[g] & ~lvl_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q   <= 1'b0;
                pend[g] <= 1'b0;
            end else begin
                lvl_q   <= lvl[g];
                pend[g] <= (edge_w & ie[g]) | (pend[g] & ~clr[g]);
            end
        end
    end

    assign irq = |pend;

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter logic [DW-1:0]      CMDB_RST = 8'h00,
    parameter logic [N_HWCMD-1:0] MASK_RST = 8'hFF,
    parameter logic [1:0]         CTRL_RST = 2'b11,
    parameter logic [DW-1:0]      PORT_RST = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_a2,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] l_addr,
    input  logic          l_rd,
    input  logic          l_wr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic [DW-1:0] in_port_i,
    input  logic [1:0]    test_in_i,
    output logic [DW-1:0] p2_o,
    output logic          kb_reset_o,
    output logic          irq_o
);

    localparam int unsigned NIRQ = 2;

    logic [DW-1:0]      ibuf_q, obuf_q, cmdb_q, port_q;
    logic [N_HWCMD-1:0] mask_q;
    logic [1:0]         ctrl_q;
    logic [3:0]         sthi_q;
    logic               a2_q, ibf_q, obf_q, kb_rst_q;
    logic [DW-1:0]      status_w;

    logic h_cmd_wr, h_dat_wr, h_dat_rd;
    logic l_wr_obuf, l_wr_cmdb, l_wr_ctrl, l_wr_iflag, l_wr_mask, l_wr_stat, l_wr_port;
    logic l_rd_ibuf;

    logic          fw_mode, fsm_ibf_set, fsm_obuf_load, fsm_aux_load, fsm_aux_val;
    logic          fsm_port_load, fsm_rst_pulse, fw_exit;
    logic [DW-1:0] fsm_obuf_val, fsm_port_next;
    logic [NIRQ-1:0] pend_w, clr_w;

    assign h_cmd_wr = h_wr &  h_a2;
    assign h_dat_wr = h_wr & ~h_a2;
    assign h_dat_rd = h_rd & ~h_a2;

    assign l_wr_obuf  = l_wr && (l_addr == LA_OBUF);
    assign l_wr_cmdb  = l_wr && (l_addr == LA_CMDB);
    assign l_wr_ctrl  = l_wr && (l_addr == LA_CTRL);
    assign l_wr_iflag = l_wr && (l_addr == LA_IFLAG);
    assign l_wr_mask  = l_wr && (l_addr == LA_MASK);
    assign l_wr_stat  = l_wr && (l_addr == LA_STAT);
    assign l_wr_port  = l_wr && (l_addr == LA_PORT);
    assign l_rd_ibuf  = l_rd && (l_addr == LA_IBUF);

    assign fw_exit = l_wr_iflag & l_wdata[2];
    assign clr_w   = l_wr_iflag ? l_wdata[NIRQ-1:0] : '0;

    kbc_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cmd_wr(h_cmd_wr),
        .host_dat_wr(h_dat_wr),
        .host_wdata (h_wdata),
        .hw_mask    (mask_q),
        .cmd_byte   (cmdb_q),
        .in_port    (in_port_i),
        .port_val   (port_q),
        .test_in    (test_in_i),
        .fw_exit    (fw_exit),
        .fw_mode    (fw_mode),
        .ibf_set    (fsm_ibf_set),
        .obuf_load  (fsm_obuf_load),
        .obuf_val   (fsm_obuf_val),
        .aux_load   (fsm_aux_load),
        .aux_val    (fsm_aux_val),
        .port_load  (fsm_port_load),
        .port_next  (fsm_port_next),
        .rst_pulse  (fsm_rst_pulse)
    );

    kbc_irq_unit #(
        .NSRC    (NIRQ),
        .FALL_SEL(2'b01)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({ibf_q, obf_q}),
        .ie   (ctrl_q),
        .clr  (clr_w),
        .pend (pend_w),
        .irq  (irq_o)
    );

    // host-facing buffers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibuf_q   <= '0;
            a2_q     <= 1'b0;
            ibf_q    <= 1'b0;
            obuf_q   <= '0;
            obf_q    <= 1'b0;
            kb_rst_q <= 1'b0;
        end else begin
            kb_rst_q <= fsm_rst_pulse;
            if (h_wr) begin
                ibuf_q <= h_wdata;
                a2_q   <= h_a2;
            end
            if (fsm_ibf_set)    ibf_q <= 1'b1;
            else if (l_rd_ibuf) ibf_q <= 1'b0;
            if (l_wr_obuf)          obuf_q <= l_wdata;
            else if (fsm_obuf_load) obuf_q <= fsm_obuf_val;
            if (l_wr_obuf || fsm_obuf_load) obf_q <= 1'b1;
            else if (h_dat_rd)              obf_q <= 1'b0;
        end
    end

    // local configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmdb_q <= CMDB_RST & 8'h7F;
            ctrl_q <= CTRL_RST;
            mask_q <= MASK_RST;
            sthi_q <= '0;
            port_q <= PORT_RST;
        end else begin
            if (l_wr_cmdb) cmdb_q <= {1'b0, l_wdata[DW-2:0]};
            if (l_wr_ctrl) ctrl_q <= l_wdata[1:0];
            if (l_wr_mask) mask_q <= l_wdata;
            if (l_wr_stat)         sthi_q    <= l_wdata[7:4];
            else if (fsm_aux_load) sthi_q[1] <= fsm_aux_val;
            if (l_wr_port)          port_q <= l_wdata;
            else if (fsm_port_load) port_q <= fsm_port_next;
        end
    end

    assign status_w   = {sthi_q, a2_q, cmdb_q[2], ibf_q, obf_q};
    assign h_rdata    = h_a2 ? status_w : obuf_q;
    assign p2_o       = port_q;
    assign kb_reset_o = kb_rst_q;

    always_comb begin
        unique case (l_addr)
            LA_IBUF:  l_rdata = ibuf_q;
            LA_OBUF:  l_rdata = obuf_q;
            LA_CMDB:  l_rdata = cmdb_q;
            LA_CTRL:  l_rdata = {6'b0, ctrl_q};
            LA_IFLAG: l_rdata = {5'b0, fw_mode, pend_w};
            LA_MASK:  l_rdata = mask_q;
            LA_STAT:  l_rdata = status_w;
            LA_PORT:  l_rdata = port_q;
        endcase
    end

endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk
    import kbc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          h_a2,
    input logic          h_rd,
    input logic          h_wr,
    input logic [AW-1:0] l_addr,
    input logic          l_wr,
    input logic [DW-1:0] l_wdata,
    input logic          kb_reset_o,
    input logic          obf,
    input logic          ibf,
    input logic          a2,
    input logic          fw_mode,
    input logic          fsm_obuf_load,
    input logic [1:0]    ctrl,
    input logic [1:0]    pend
);

    a_r3_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && l_addr == LA_OBUF) |=> obf);

    a_r4_obf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !h_a2 && !(l_wr && l_addr == LA_OBUF) && !fsm_obuf_load) |=> !obf);

    a_r2_a2_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_a2) |=> a2);

    a_r2_a2_data: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !h_a2) |=> !a2);

    a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        kb_reset_o |=> !kb_reset_o);

    a_r9_fw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_mode && !(l_wr && l_addr == LA_IFLAG && l_wdata[2])) |=> fw_mode);

    a_r10_ibf_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ibf) && ctrl[1]) |=> pend[1]);

endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_a2         (h_a2),
    .h_rd         (h_rd),
    .h_wr         (h_wr),
    .l_addr       (l_addr),
    .l_wr         (l_wr),
    .l_wdata      (l_wdata),
    .kb_reset_o   (kb_reset_o),
    .obf          (obf_q),
    .ibf          (ibf_q),
    .a2           (a2_q),
    .fw_mode      (fw_mode),
    .fsm_obuf_load(fsm_obuf_load),
    .ctrl         (ctrl_q),
    .pend         (pend_w)
);

// File: tb/kbc_host_if_test.sv
module kbc_host_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_a2 = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
    logic [7:0] h_wdata = '0, h_rdata;
    logic [2:0] l_addr = '0;
    logic       l_rd = 1'b0, l_wr = 1'b0;
    logic [7:0] l_wdata = '0, l_rdata;
    logic [7:0] in_port_i = 8'hA7;
    logic [1:0] test_in_i = 2'b10;
    logic [7:0] p2_o;
    logic       kb_reset_o, irq_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] port_exp;
    logic [7:0] rd;

    always #2 clk = ~clk;

    kbc_host_if uut (
        .clk(clk), .rst_n(rst_n),
        .h_a2(h_a2), .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_addr(l_addr), .l_rd(l_rd), .l_wr(l_wr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .in_port_i(in_port_i), .test_in_i(test_in_i), .p2_o(p2_o),
        .kb_reset_o(kb_reset_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_wr(input logic a2, input logic [7:0] d);
        @(negedge clk);
        h_a2 = a2; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic host_rd(input logic a2, output logic [7:0] d);
        @(negedge clk);
        h_a2 = a2; h_rd = 1'b1;
        #1 d = h_rdata;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic loc_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        l_addr = a; l_wdata = d; l_wr = 1'b1;
        @(negedge clk);
        l_wr = 1'b0;
    endtask

    task automatic loc_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        l_addr = a; l_rd = 1'b1;
        #1 d = l_rdata;
        @(negedge clk);
        l_rd = 1'b0;
    endtask

    // status read without side effects (A2 = 1, combinational)
    function automatic logic [7:0] status_now();
        return uut.h_rdata;
    endfunction

    task automatic get_status(output logic [7:0] s);
        h_a2 = 1'b1;
        #1 s = h_rdata;
    endtask

    function automatic int hw_index(input logic [7:0] c);
        case (c)
            8'h20: return 0;
            8'hC0: return 1;
            8'hD0: return 2;
            8'hD1: return 3;
            8'hD2: return 4;
            8'hD3: return 5;
            8'hE0: return 6;
            8'hFE: return 7;
            default: return 8;
        endcase
    endfunction

    // firmware path check and cleanup; expects IBF rising edge to be latched
    task automatic expect_fw(input logic [7:0] c, input string tag);
        logic [7:0] s, v;
        tick();
        get_status(s);
        chk({tag, " R9 ibf set"}, s & 8'h0B, 8'h0A);
        loc_rd(3'd4, v);
        chk({tag, " R9 R10 fw flag and ibf pending"}, v, 8'h06);
        chk({tag, " R10 irq"}, {7'b0, irq_o}, 8'h01);
        host_wr(1'b0, ~c);
        tick();
        get_status(s);
        chk({tag, " R9 fw data still ibf, a2=0"}, s & 8'h0B, 8'h02);
        loc_rd(3'd0, v);
        chk({tag, " R2 input buffer"}, v, ~c);
        tick();
        get_status(s);
        chk({tag, " R11 ibf cleared by local read"}, s & 8'h02, 8'h00);
        loc_wr(3'd4, 8'h07);
        tick();
        loc_rd(3'd4, v);
        chk({tag, " R9 R10 fw exit and pend clear"}, v, 8'h00);
    endtask

    task automatic drain_obuf(input logic [7:0] exp, input string tag);
        logic [7:0] s, v;
        get_status(s);
        chk({tag, " R6 obf set, ibf clear"}, s & 8'h03, 8'h01);
        host_rd(1'b0, v);
        chk({tag, " R3 output buffer value"}, v, exp);
        tick();
        get_status(s);
        chk({tag, " R4 obf cleared by host read"}, s & 8'h01, 8'h00);
        loc_rd(3'd4, v);
        chk({tag, " R10 obf falling pending"}, v, 8'h01);
        loc_wr(3'd4, 8'h01);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] s, v, x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset values
        get_status(s);
        chk("R1 status", s, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk("R1 kb_reset", {7'b0, kb_reset_o}, 8'h00);
        loc_rd(3'd3, v); chk("R1 control", v, 8'h03);
        loc_rd(3'd5, v); chk("R1 mask", v, 8'hFF);
        loc_rd(3'd2, v); chk("R1 command byte", v, 8'h00);
        loc_rd(3'd4, v); chk("R1 iflags", v, 8'h00);
        loc_rd(3'd7, v); chk("R1 port", v, 8'h00);

        // R12 command byte bit7 forced to 0, R5 system flag mirror
        loc_wr(3'd2, 8'hC5);
        loc_rd(3'd2, v); chk("R12 command byte", v, 8'h45);
        port_exp = 8'h3C;
        loc_wr(3'd7, port_exp);

        // R5 sweep of locally written status bits
        for (int k = 0; k < 16; k++) begin
            loc_wr(3'd6, 8'(k << 4));
            tick();
            get_status(s);
            chk("R5 status layout", s, {4'(k), 4'b0100});
        end
        loc_wr(3'd6, 8'h00);

        // R3 R4 R10 local output buffer path
        loc_wr(3'd1, 8'h96);
        tick();
        drain_obuf(8'h96, "local obuf");
        tick();
        chk("R10 irq cleared", {7'b0, irq_o}, 8'h00);

        // R11 R2 host data byte in idle
        host_wr(1'b0, 8'h33);
        tick();
        get_status(s);
        chk("R11 R2 idle data write", s & 8'h0B, 8'h02);
        tick();
        loc_rd(3'd4, v); chk("R10 ibf rising pending", v, 8'h02);
        loc_rd(3'd0, v); chk("R2 input buffer data", v, 8'h33);
        loc_wr(3'd4, 8'h02);
        tick();
        get_status(s);
        chk("R11 ibf cleared", s & 8'h02, 8'h00);

        // exhaustive command sweep with full mask
        for (int c = 0; c < 256; c++) begin
            int idx;
            idx = hw_index(8'(c));
            host_wr(1'b1, 8'(c));
            tick();
            chk("R8 reset pulse cycle", {7'b0, kb_reset_o}, {7'b0, idx == 7});
            get_status(s);
            chk("R2 a2 after command", s & 8'h08, 8'h08);
            tick();
            chk("R8 reset one cycle only", {7'b0, kb_reset_o}, 8'h00);
            case (idx)
                0: drain_obuf(8'h45, "R6 cmd20");
                1: drain_obuf(8'hA7, "R6 cmdC0");
                2: drain_obuf(port_exp, "R6 cmdD0");
                6: drain_obuf(8'h02, "R6 cmdE0");
                3: begin
                    x = 8'(c) ^ 8'h5A;
                    host_wr(1'b0, x);
                    tick();
                    port_exp = x;
                    chk("R7 D1 port", p2_o, x);
                    get_status(s);
                    chk("R7 D1 no ibf no obf", s & 8'h03, 8'h00);
                end
                4, 5: begin
                    x = 8'(c) ^ 8'h5A;
                    host_wr(1'b0, x);
                    tick();
                    get_status(s);
                    chk("R7 aux flag", s & 8'h20, (idx == 5) ? 8'h20 : 8'h00);
                    drain_obuf(x, "R7 loopback");
                    loc_wr(3'd6, 8'h00);
                end
                7: begin
                    get_status(s);
                    chk("R8 FE no buffer change", s & 8'h03, 8'h00);
                end
                default: expect_fw(8'(c), "unknown");
            endcase
        end

        // each hardware command masked off goes to firmware
        for (int k = 0; k < 8; k++) begin
            logic [7:0] codes [8];
            codes = '{8'h20, 8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hE0, 8'hFE};
            loc_wr(3'd5, ~(8'h01 << k));
            host_wr(1'b1, codes[k]);
            tick();
            chk("R9 masked no reset", {7'b0, kb_reset_o}, 8'h00);
            expect_fw(codes[k], "masked");
        end
        loc_wr(3'd5, 8'hFF);
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule